// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, A and B, and can pass a word in either direction. Each direction owns a storage register with its own capture clock. The A-to-B register takes the A bus on its clock, and the B-to-A register takes the B bus on its clock. When a bus is driven, a per-direction select decides what it carries. It either passes the word on the opposite bus straight through with no clock, or it presents the word held in that direction's register.

An active-low output enable and a direction input decide which bus, if either, is driven. With the enable inactive, both buses float and the block works only as a pair of capture registers. Capture does not depend on the output controls, so a word can be stored from a bus while the block is driving the other bus or driving nothing. Tri-state pads are modelled as separate input, output and output-enable vectors for each bus. An undriven output reads zero.

Top module: `xcvr_reg_bridge`

## Requirements
- R1: Both data paths are `DATA_W` bits wide, 8 by default.
- R2: A rising edge of `clk_ab` with `rst_n` high stores `a_in` in the A-to-B register. A rising edge of `clk_ba` with `rst_n` high stores `b_in` in the B-to-A register. A pulse on one clock leaves the other register unchanged.
- R3: Capture works the same for every value of `oe_n`, `dir`, `sel_ab` and `sel_ba`, including isolation and the case where the other bus is being driven.
- R4: When `oe_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both 0.
- R5: `a_oe` and `b_oe` are never 1 at the same time.
- R6: When `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0. `b_out` equals `a_in` when `sel_ab` is 0, or the A-to-B register when `sel_ab` is 1. `a_out` is 0.
- R7: When `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0. `a_out` equals `b_in` when `sel_ba` is 0, or the B-to-A register when `sel_ba` is 1. `b_out` is 0.
- R8: Reset is synchronous and active low. A rising edge of a register's clock while `rst_n` is 0 clears that register to zero.
- R9: The outputs follow changes on the data, select and control inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Synchronous active-low clear, sampled by both clocks |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 drives B from the A path, 0 drives A from the B path |
| sel_ab | input | 1 | A-to-B source: 0 live A bus, 1 stored word |
| sel_ba | input | 1 | B-to-A source: 0 live B bus, 1 stored word |
| a_in | input | DATA_W | Value seen on the A pads |
| a_out | output | DATA_W | Value driven onto the A pads |
| a_oe | output | 1 | A pad driver enable |
| b_in | input | DATA_W | Value seen on the B pads |
| b_out | output | DATA_W | Value driven onto the B pads |
| b_oe | output | 1 | B pad driver enable |

## Verification
A stored word can only be seen at the ports when its direction drives and its select picks the register. A corrupted or missed capture therefore stays hidden until the first stimulus that sets those controls. After that it shows at once, with no clock, as a wrong word on `a_out` or `b_out`. A fault in the enable decode shows as soon as the controls settle: one bus goes undriven or both are driven together, and no clock is needed to see it. For these reasons the bench reads each register through the driven path after every capture, reset and isolation step. It also walks all sixteen control combinations against two different stored words.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int unsigned XCVR_DATA_W = 8;
    localparam int unsigned XCVR_LANES  = 2;   // index 0: A to B, index 1: B to A

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.word = '0;
        end else begin
            st_d.word = d_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.word;

    // R2: the word present at the previous edge is what the register now holds
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_o == $past(d_i)));

    // R8: the first edge after reset release still shows the cleared word
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (q_o == '0));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int unsigned W = 8
) (
    input  logic         drive_en_i,
    input  logic         sel_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] stored_i,
    output logic [W-1:0] out_o,
    output logic         oe_o
);
    import xcvr_pkg::*;

    src_sel_e     src;
    logic [W-1:0] pick;

    always_comb begin
        src  = src_sel_e'(sel_i);
        pick = (src == SRC_STORED) ? stored_i : live_i;
        oe_o  = drive_en_i;
        out_o = drive_en_i ? pick : '0;
    end
endmodule

// File: rtl/xcvr_reg_bridge.sv
module xcvr_reg_bridge #(
    parameter int unsigned DATA_W = xcvr_pkg::XCVR_DATA_W
) (
    input  logic              clk_ab,
    input  logic              clk_ba,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              dir,
    input  logic              sel_ab,
    input  logic              sel_ba,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe
);
    import xcvr_pkg::*;

    localparam int unsigned N = XCVR_LANES;

    logic              lane_clk [N];
    logic              lane_sel [N];
    logic              lane_en  [N];
    logic [DATA_W-1:0] lane_src [N];
    logic [DATA_W-1:0] lane_reg [N];
    logic [DATA_W-1:0] lane_out [N];
    logic              lane_oe  [N];

    always_comb begin
        lane_clk[0] = clk_ab;
        lane_clk[1] = clk_ba;
        lane_sel[0] = sel_ab;
        lane_sel[1] = sel_ba;
        lane_src[0] = a_in;
        lane_src[1] = b_in;
        lane_en[0]  = !oe_n &&  dir;
        lane_en[1]  = !oe_n && !dir;
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        xcvr_store #(.W(DATA_W)) u_store (
            .clk   (lane_clk[g]),
            .rst_n (rst_n),
            .d_i   (lane_src[g]),
            .q_o   (lane_reg[g])
        );
        xcvr_lane #(.W(DATA_W)) u_lane (
            .drive_en_i (lane_en[g]),
            .sel_i      (lane_sel[g]),
            .live_i     (lane_src[g]),
            .stored_i   (lane_reg[g]),
            .out_o      (lane_out[g]),
            .oe_o       (lane_oe[g])
        );
    end

    assign b_out = lane_out[0];
    assign b_oe  = lane_oe[0];
    assign a_out = lane_out[1];
    assign a_oe  = lane_oe[1];

    // R5: never both pad drivers on
    p_one_bus_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !(a_oe && b_oe));

    // R4: isolation leaves both buses undriven
    p_isolate_r4: assert property (@(posedge clk_ba) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    // R6: transparent A to B path
    p_live_ab_r6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> (b_out == a_in));

    // R7: transparent B to A path
    p_live_ba_r7: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (a_oe && !sel_ba) |-> (a_out == b_in));
endmodule

// File: tb/tb_xcvr_reg_bridge.sv
module tb_xcvr_reg_bridge;
    localparam int W = 8;

    // {oe_n,dir,sel_ab,sel_ba}, a_oe, b_oe, a_src, b_src  (src: 0 zero, 1 live, 2 stored)
    localparam logic [9:0] VEC [16] = '{
        {4'b0000, 1'b1, 1'b0, 2'd1, 2'd0},
        {4'b0001, 1'b1, 1'b0, 2'd2, 2'd0},
        {4'b0010, 1'b1, 1'b0, 2'd1, 2'd0},
        {4'b0011, 1'b1, 1'b0, 2'd2, 2'd0},
        {4'b0100, 1'b0, 1'b1, 2'd0, 2'd1},
        {4'b0101, 1'b0, 1'b1, 2'd0, 2'd1},
        {4'b0110, 1'b0, 1'b1, 2'd0, 2'd2},
        {4'b0111, 1'b0, 1'b1, 2'd0, 2'd2},
        {4'b1000, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b1001, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b1010, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b1011, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b1100, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b1101, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b1110, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b1111, 1'b0, 1'b0, 2'd0, 2'd0}
    };

    logic         clk = 0;
    logic         clk_ab = 0, clk_ba = 0, rst_n = 0;
    logic         oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    xcvr_reg_bridge #(.DATA_W(W)) dut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
        .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_ab();
        @(posedge clk); #1 clk_ab = 1; #1 clk_ab = 0; #1;
    endtask

    task automatic pulse_ba();
        @(posedge clk); #1 clk_ba = 1; #1 clk_ba = 0; #1;
    endtask

    task automatic set_ctl(input logic [3:0] c);
        {oe_n, dir, sel_ab, sel_ba} = c;
        #1;
    endtask

    // read the stored words through the driven paths (R6, R7)
    task automatic read_regs(output logic [W-1:0] rab, output logic [W-1:0] rba);
        set_ctl(4'b0110); rab = b_out;
        set_ctl(4'b0001); rba = a_out;
    endtask

    task automatic run_table(input logic [W-1:0] sab, input logic [W-1:0] sba);
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] ea, eb;
            set_ctl(VEC[i][9:6]);
            ea = (VEC[i][3:2] == 2'd1) ? b_in : (VEC[i][3:2] == 2'd2) ? sba : '0;
            eb = (VEC[i][1:0] == 2'd1) ? a_in : (VEC[i][1:0] == 2'd2) ? sab : '0;
            check("R4/R5 a_oe", {7'd0, a_oe}, {7'd0, VEC[i][5]});
            check("R4/R5 b_oe", {7'd0, b_oe}, {7'd0, VEC[i][4]});
            check("R7 a_out", a_out, ea);
            check("R6 b_out", b_out, eb);
        end
    endtask

    initial begin
        logic [W-1:0] rab, rba;
        a_in = 8'hFF; b_in = 8'hEE;
        repeat (2) begin pulse_ab(); pulse_ba(); end
        rst_n = 1;
        // R8: reset clears both registers
        read_regs(rab, rba);
        check("R8 ab reset", rab, 8'h00);
        check("R8 ba reset", rba, 8'h00);
        set_ctl(4'b1000);
        check("R4 reset iso a_oe", {7'd0, a_oe}, 8'h00);

        // R2: independent captures
        a_in = 8'h3C; pulse_ab();
        read_regs(rab, rba);
        check("R2 ab capture", rab, 8'h3C);
        check("R2 ba untouched", rba, 8'h00);
        b_in = 8'hA5; pulse_ba();
        read_regs(rab, rba);
        check("R2 ba capture", rba, 8'hA5);
        check("R2 ab untouched", rab, 8'h3C);

        a_in = 8'h5A; b_in = 8'hC3;
        run_table(8'h3C, 8'hA5);

        // R9: live path follows input change with no clock
        set_ctl(4'b0100); a_in = 8'h81; #1;
        check("R9 live follow b_out", b_out, 8'h81);
        set_ctl(4'b0000); b_in = 8'h7E; #1;
        check("R9 live follow a_out", a_out, 8'h7E);

        // R3: capture in isolation mode
        set_ctl(4'b1111); a_in = 8'h11; b_in = 8'h22;
        pulse_ab(); pulse_ba();
        read_regs(rab, rba);
        check("R3 iso ab", rab, 8'h11);
        check("R3 iso ba", rba, 8'h22);

        // R3: capture B->A register while B is being driven
        set_ctl(4'b0100); b_in = 8'h99; pulse_ba();
        read_regs(rab, rba);
        check("R3 drive-side ba", rba, 8'h99);

        a_in = 8'h0F; b_in = 8'hF0;
        run_table(8'h11, 8'h99);

        // R8: reset pulses on one clock only clear that register
        rst_n = 0; pulse_ab(); rst_n = 1;
        read_regs(rab, rba);
        check("R8 ab cleared", rab, 8'h00);
        check("R8 ba kept", rba, 8'h99);
        rst_n = 0; pulse_ba(); rst_n = 1;
        read_regs(rab, rba);
        check("R8 ba cleared", rba, 8'h00);

        // R1: full width path, all bits
        a_in = 8'hFF; pulse_ab();
        read_regs(rab, rba);
        check("R1 width", rab, 8'hFF);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule